// File: doc/BRIEF.md
# Voltage-Binning Quasi-Sort Engine

This block ranks the sub-modules of one converter arm by capacitor voltage without a comparison network. After a start strobe it accepts exactly N voltage samples on a valid/ready input stream, one per sub-module in physical order, each with the sub-module's inserted/bypassed flag. The band between two design constants, a low and a high voltage bound, is cut into M slices of equal width. Each sample goes to a slice index between 0 and M, and the sub-module's position index is queued, with its flag, in a small FIFO kept for that index. The index is the offset from the low bound, scaled by M over the span, and rounded half-up.

Once the N-th sample is taken, the block empties the bins in index order and streams out position/flag words. The order is lowest slice first when the direction input is low, and highest slice first when it is high. Within one slice, words leave in arrival order. A controller can act on the first word while the rest are still coming. The output is valid/ready. The block never drops out_valid and never changes the presented word until the consumer takes it. The consumer may hold out_ready low for any number of cycles. Back-pressure only stretches the read phase. The busy pin stays high from start until the last bin is emptied, and start is ignored while busy is high.

Top module: `vbin_sorter`

## Requirements
- R1: During and right after reset, busy, in_ready and out_valid are all 0.
- R2: A start pulse while idle latches dir, and in the next cycle busy and in_ready are 1. Exactly N input transfers are then accepted, and in_ready is 0 at all other times.
- R3: Slice index = floor((v − VMIN)·M/(VMAX − VMIN) + 1/2), which is round-half-up. With the defaults (VMIN=1024, VMAX=3072, M=8) slice k covers offsets 256k−128 to 256k+127.
- R4: Samples below VMIN go to slice 0, and samples at or above VMAX go to slice M.
- R5: Sub-modules that share a slice are emitted in the order their samples arrived. One slice can hold all N entries.
- R6: With dir=0 the output walks slices 0 up to M.
- R7: With dir=1 the output walks slices M down to 0.
- R8: Each run emits exactly N words. The word carries out_pos, which is the position (0 for the first sample accepted after start), and out_stat, which is the flag given with that sample.
- R9: While out_valid=1 and out_ready=0, out_valid stays 1 and out_pos/out_stat keep their value in the next cycle.
- R10: A start pulse while busy=1 has no effect on the run in progress.
- R11: busy returns to 0 after the last word, and a new start discards everything left from earlier runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a new conversion set when idle |
| dir | input | 1 | 0 ascending, 1 descending; sampled with start |
| in_valid | input | 1 | Voltage sample present |
| in_ready | output | 1 | Block takes a sample this cycle |
| in_volt | input | VW | Measured capacitor voltage code |
| in_stat | input | 1 | Inserted (1) / bypassed (0) flag of this sub-module |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_pos | output | clog2(N) | Sub-module position index |
| out_stat | output | 1 | Flag stored with that position |
| busy | output | 1 | A run is in progress |

## Verification
The bench aims at the rounding edges: the two codes on either side of a half-slice boundary. A divider that truncates instead of rounding would put those sub-modules one slice too low and break the order. It drives codes outside the band and exactly at the top bound, which a design without clamping would send into a missing bin. One run puts every sample in a single slice. This catches a bin that is too shallow, which would lose words, and a bin that pops newest-first, which would reverse the order. Random stalls on out_ready and stray start pulses in both phases show up as a held word that changes, a duplicate or missing word, or a restarted run. Back-to-back runs expose pointers that are not cleared, as extra words.

// File: rtl/vbin_pkg.sv
package vbin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } vbin_state_e;
endpackage

// File: rtl/vbin_mapper.sv
// Maps a voltage code to a slice index by reciprocal multiply and round-half-up.
module vbin_mapper #(
  parameter int VW   = 12,
  parameter int M    = 8,
  parameter int VMIN = 1024,
  parameter int VMAX = 3072,
  parameter int FB   = 16,
  localparam int AW  = $clog2(M + 1)
) (
  input  logic [VW-1:0] volt,
  output logic [AW-1:0] addr
);
  localparam int SPAN  = VMAX - VMIN;
  localparam longint RECIP = ((longint'(M) << FB) + SPAN / 2) / SPAN;
  localparam int PRW   = VW + FB + AW + 2;
  localparam logic [PRW-1:0] HALF = PRW'(1) << (FB - 1);

  logic [VW-1:0]  off;
  logic [PRW-1:0] prod;
  logic [PRW-1:0] rnd;

  always_comb begin
    if (int'(volt) < VMIN) off = '0;
    else                   off = VW'(int'(volt) - VMIN);
    prod = PRW'(off) * PRW'(RECIP);
    rnd  = (prod + HALF) >> FB;
    if (int'(volt) >= VMAX)      addr = AW'(M);
    else if (rnd > PRW'(M))      addr = AW'(M);
    else                         addr = rnd[AW-1:0];
  end
endmodule

// File: rtl/vbin_fifo.sv
// One slice bin: filled during the write phase, drained during the read phase.
module vbin_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 7,
  localparam int IW   = $clog2(DEPTH),
  localparam int PTRW = IW + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] wptr;
  logic [PTRW-1:0] rptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push && !full) wptr <= wptr + 1'b1;
      if (pop && !empty) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr[IW-1:0]] <= wdata;
  end

  assign rdata = mem[rptr[IW-1:0]];
  assign empty = (rptr == wptr);
  assign full  = (wptr == PTRW'(DEPTH));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/vbin_ctrl.sv
// Sequencer: write phase counts positions, read phase walks slice indices.
module vbin_ctrl
  import vbin_pkg::*;
#(
  parameter int N  = 64,
  parameter int M  = 8,
  localparam int AW = $clog2(M + 1),
  localparam int PW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir,
  input  logic          in_valid,
  input  logic          cur_empty,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic          push,
  output logic          pop,
  output logic          clr,
  output logic [PW-1:0] pos,
  output logic [AW-1:0] cur,
  output logic          busy
);
  vbin_state_e state;
  logic        dir_q;
  logic [AW-1:0] last_addr;

  assign last_addr = dir_q ? '0 : AW'(M);
  assign busy      = (state != ST_IDLE);
  assign in_ready  = (state == ST_WRITE);
  assign push      = in_ready && in_valid;
  assign out_valid = (state == ST_READ) && !cur_empty;
  assign pop       = out_valid && out_ready;
  assign clr       = (state == ST_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      dir_q <= 1'b0;
      pos   <= '0;
      cur   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            dir_q <= dir;
            pos   <= '0;
            state <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (in_valid) begin
            pos <= pos + 1'b1;
            if (pos == PW'(N - 1)) begin
              state <= ST_READ;
              cur   <= dir_q ? AW'(M) : '0;
            end
          end
        end
        ST_READ: begin
          if (cur_empty) begin
            if (cur == last_addr) state <= ST_IDLE;
            else if (dir_q)       cur <= cur - 1'b1;
            else                  cur <= cur + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R6
  asc_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && $past(state == ST_READ) && !dir_q) |-> cur >= $past(cur));
  // R7
  desc_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && $past(state == ST_READ) && dir_q) |-> cur <= $past(cur));
endmodule

// File: rtl/vbin_sorter.sv
module vbin_sorter #(
  parameter int N    = 64,
  parameter int M    = 8,
  parameter int VW   = 12,
  parameter int VMIN = 1024,
  parameter int VMAX = 3072,
  localparam int AW  = $clog2(M + 1),
  localparam int PW  = $clog2(N),
  localparam int W   = PW + 1,
  localparam int NB  = M + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [VW-1:0] in_volt,
  input  logic          in_stat,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_pos,
  output logic          out_stat,
  output logic          busy
);
  logic [AW-1:0] waddr;
  logic [AW-1:0] cur;
  logic [PW-1:0] pos;
  logic          push, pop, clr;
  logic [NB-1:0] bin_empty;
  logic [NB-1:0] bin_full;
  logic [W-1:0]  bin_rdata [NB];
  logic          cur_empty;
  logic [W-1:0]  cur_word;

  vbin_mapper #(.VW(VW), .M(M), .VMIN(VMIN), .VMAX(VMAX)) u_map (
    .volt (in_volt),
    .addr (waddr)
  );

  vbin_ctrl #(.N(N), .M(M)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dir       (dir),
    .in_valid  (in_valid),
    .cur_empty (cur_empty),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .push      (push),
    .pop       (pop),
    .clr       (clr),
    .pos       (pos),
    .cur       (cur),
    .busy      (busy)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bin
    vbin_fifo #(.DEPTH(N), .W(W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .push  (push && (waddr == AW'(b))),
      .wdata ({in_stat, pos}),
      .pop   (pop && (cur == AW'(b))),
      .rdata (bin_rdata[b]),
      .empty (bin_empty[b]),
      .full  (bin_full[b])
    );
  end

  always_comb begin
    cur_empty = 1'b1;
    cur_word  = '0;
    for (int b = 0; b < NB; b++) begin
      if (cur == AW'(b)) begin
        cur_empty = bin_empty[b];
        cur_word  = bin_rdata[b];
      end
    end
  end

  assign out_pos  = cur_word[PW-1:0];
  assign out_stat = cur_word[W-1];

  // R9
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pos) && $stable(out_stat)));
  // R2
  write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && !out_valid));
endmodule

// File: tb/sim_vbin_sorter.sv
module sim_vbin_sorter;
  localparam int N = 64, M = 8, VW = 12, VMIN = 1024, VMAX = 3072;
  localparam int PW = $clog2(N);
  localparam int SPAN = VMAX - VMIN;

  logic clk = 0, rst_n = 0;
  logic start = 0, dir = 0, in_valid = 0, in_stat = 0, out_ready = 0;
  logic [VW-1:0] in_volt = '0;
  logic in_ready, out_valid, out_stat, busy;
  logic [PW-1:0] out_pos;

  int total = 0, bad = 0;
  bit finished = 0;
  int volts [N];
  bit stats [N];
  int exp_pos [N];

  always #10 clk = ~clk;

  vbin_sorter #(.N(N), .M(M), .VW(VW), .VMIN(VMIN), .VMAX(VMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dir(dir),
    .in_valid(in_valid), .in_ready(in_ready), .in_volt(in_volt), .in_stat(in_stat),
    .out_valid(out_valid), .out_ready(out_ready), .out_pos(out_pos),
    .out_stat(out_stat), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // R3 rounding, R4 clamping
  function automatic int slice_of(input int v);
    int off;
    if (v < VMIN) return 0;
    if (v >= VMAX) return M;
    off = v - VMIN;
    return (2 * off * M + SPAN) / (2 * SPAN);
  endfunction

  // R5 arrival order inside a slice, R6/R7 slice order
  task automatic build_expected(input bit d);
    int k = 0;
    for (int s = 0; s <= M; s++) begin
      int b = d ? (M - s) : s;
      for (int i = 0; i < N; i++)
        if (slice_of(volts[i]) == b) begin
          exp_pos[k] = i;
          k++;
        end
    end
  endtask

  task automatic do_run(input bit d, input bit poke_w, input bit poke_r,
                        input bit stall, input string tag);
    int i = 0, got = 0, guard = 0;
    bit held = 0;
    logic [PW:0] hold_w = '0;
    build_expected(d);
    @(negedge clk); start = 1; dir = d;
    @(negedge clk); start = 0; dir = ~d;
    check(busy === 1'b1 && in_ready === 1'b1, "R2 start", {busy, in_ready}, 3);
    while (i < N) begin
      in_valid = ($urandom % 4) != 0;
      in_volt  = VW'(volts[i]);
      in_stat  = stats[i];
      start    = poke_w && (i == N / 2);
      if (in_valid && in_ready) i++;
      @(negedge clk);
    end
    in_valid = 0; start = 0;
    while (guard < 4000) begin
      guard++;
      if (held)
        check(out_valid === 1'b1 && {out_stat, out_pos} === hold_w, "R9 stall hold",
              int'({out_stat, out_pos}), int'(hold_w));
      if (!busy) break;
      check(in_ready === 1'b0, "R2 ready outside write", in_ready, 0);
      out_ready = stall ? (($urandom % 3) != 0) : 1'b1;
      start = poke_r && (got == 5);
      if (out_valid && out_ready) begin
        if (got < N)
          check(out_pos == PW'(exp_pos[got]) && out_stat == stats[exp_pos[got]],
                {tag, " order/status R8"}, int'({out_stat, out_pos}),
                int'({stats[exp_pos[got]], PW'(exp_pos[got])}));
        got++;
      end
      held = out_valid && !out_ready;
      hold_w = {out_stat, out_pos};
      @(negedge clk);
    end
    start = 0; out_ready = 0;
    check(got == N, "R8 word count", got, N);
    check(busy === 1'b0 && out_valid === 1'b0, "R11 idle after run", {busy, out_valid}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5173));
    repeat (3) @(negedge clk);
    // R1
    check(busy === 1'b0 && in_ready === 1'b0 && out_valid === 1'b0, "R1 in reset",
          {busy, in_ready, out_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    check(busy === 1'b0 && in_ready === 1'b0 && out_valid === 1'b0, "R1 after reset",
          {busy, in_ready, out_valid}, 0);

    // R3 R4: half-slice edges and out-of-band codes
    for (int i = 0; i < N; i++) begin
      case (i % 10)
        0: volts[i] = VMIN - 1;
        1: volts[i] = 0;
        2: volts[i] = VMIN + 127;
        3: volts[i] = VMIN + 128;
        4: volts[i] = VMIN + 383;
        5: volts[i] = VMIN + 384;
        6: volts[i] = VMAX - 129;
        7: volts[i] = VMAX - 128;
        8: volts[i] = VMAX;
        default: volts[i] = 4095;
      endcase
      stats[i] = i[0];
    end
    do_run(1'b0, 1'b0, 1'b0, 1'b0, "R3 R4 R6 asc edges");
    do_run(1'b1, 1'b0, 1'b0, 1'b1, "R3 R4 R7 desc edges");

    // R5: every sample in one slice, stray starts in both phases (R10)
    for (int i = 0; i < N; i++) begin
      volts[i] = VMIN + 1000;
      stats[i] = (i % 3) == 0;
    end
    do_run(1'b1, 1'b1, 1'b1, 1'b1, "R5 R10 single slice");

    // random sets, back-to-back (R11 clearing)
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < N; i++) begin
        if (($urandom % 16) == 0) volts[i] = $urandom % 4096;
        else volts[i] = 900 + ($urandom % 2300);
        stats[i] = $urandom % 2;
      end
      do_run(r[0], r[1], r[2], 1'b1, r[0] ? "R7 R11 random" : "R6 R11 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule